// File: doc/BRIEF.md
# Line loss-of-signal detector

This block watches the recovered serial bit stream of one line channel. It raises a digital loss flag when the zeros run on for too long. The flag drops again once the line carries enough ones to show that the signal is back. A comparator outside the block supplies an analog loss input. Each of the two loss sources can be masked on its own, and what remains of them is ORed into the receive loss output. A mode input picks one of two rule sets.

In the DS3/STS-1 rule set, declaration counts consecutive zeros. Clearance instead counts the ones in back-to-back windows of the same configured length. In the E3 rule set, declaration also counts consecutive zeros, and clearance waits a configured number of bit periods after the first one that follows the loss. A data-valid strobe qualifies each bit, and a small register interface carries the masks, the two length settings and the status bits.

Top module: `los_monitor`

## Requirements
- R1: After a synchronous active-high reset, `rlos` is 0 and the status word reads 0. The mask register (address 0) reads 0, the run threshold (address 1) reads 175 and the E3 clear length (address 2) reads 32.
- R2: In DS3 mode (`e3_mode`=0), the digital loss flag sets on the valid bit that completes a run of N consecutive zeros, where N is the address-1 value clamped to 100..250. A one restarts the run.
- R3: In DS3 mode, while the digital flag is set, the valid bits form windows of N bits, starting with the first bit after declaration. At the end of each window the flag clears if 3 x (ones in the window) > N, and otherwise a new window begins.
- R4: `rlos` = (digital flag AND NOT digital mask) OR (`alos_in` AND NOT analog mask). The status word (address 3) has bit 0 = digital flag, bit 1 = `alos_in`, bit 2 = `rlos`, and all other bits 0.
- R5: Address-0 bit 0 masks the digital source and bit 1 masks the analog source. With both bits set, `rlos` stays 0 whatever the flag and `alos_in` do.
- R6: In E3 mode (`e3_mode`=1), the digital flag sets after a run of consecutive valid zeros whose length is the address-1 value clamped to 10..255.
- R7: In E3 mode, while the flag is set, the first valid one starts a count. The flag clears on the M-th valid bit counted from that one, inclusive, where M is the address-2 value clamped to 10..255. A fresh completed zero run before that point cancels the count.
- R8: Bits presented with `bit_valid`=0 advance no counter.
- R9: A change of `e3_mode` restarts the zero-run and clearance counters and leaves the flag unchanged for that cycle.
- R10: The run threshold is captured at the first zero of each run, and the window length at the first bit of each window. A register write in the middle of a count takes effect only at the next run or window.
- R11: Addresses 1 and 2 read back the raw written value, before clamping. Writes to address 3 have no effect.
- R12: A run-threshold value below the DS3 minimum is raised to 100 in DS3 mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_valid | input | 1 | Qualifies `bit_in` in this cycle |
| bit_in | input | 1 | Recovered line bit |
| e3_mode | input | 1 | 0 selects DS3/STS-1 rules, 1 selects E3 rules |
| alos_in | input | 1 | Analog loss indication from the external comparator |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational on `reg_addr` |
| rlos | output | 1 | Receive loss-of-signal |

## Verification
A zero-run counter that has drifted shows up as a declaration that comes early or late by a fixed number of bits. A stale captured threshold shows up the same way, but only on the run after a register write. A corrupted window ones count either holds `rlos` high for an extra window of N bits or drops it one window too soon. The bench therefore compares `rlos` and status bit 0 after every bit, so any such slip appears in the same cycle the wrong edge happens. A failed mode restart shows up as a declaration that counts zeros seen before the mode change.

// File: rtl/los_pkg.sv
package los_pkg;

  typedef enum logic [1:0] {
    LA_MASK   = 2'd0,
    LA_THR    = 2'd1,
    LA_E3LEN  = 2'd2,
    LA_STATUS = 2'd3
  } los_addr_e;

  // limit a register setting to the legal range of the active rule set
  function automatic int fit_range(input int v, input int lo, input int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  // density test: more than one third of the window must be ones
  function automatic logic dense_enough(input int ones, input int len);
    return (ones * 3) > len;
  endfunction

endpackage

// File: rtl/los_regs.sv
module los_regs #(
  parameter int W          = 8,
  parameter int DEF_THR    = 175,
  parameter int DEF_E3_LEN = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  input  logic [2:0]   status,
  output logic [W-1:0] rdata,
  output logic         dig_dis,
  output logic         ana_dis,
  output logic [W-1:0] thr_raw,
  output logic [W-1:0] e3_raw
);
  import los_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      dig_dis <= 1'b0;
      ana_dis <= 1'b0;
      thr_raw <= W'(DEF_THR);
      e3_raw  <= W'(DEF_E3_LEN);
    end else if (wr_en) begin
      unique case (los_addr_e'(addr))
        LA_MASK:   begin dig_dis <= wdata[0]; ana_dis <= wdata[1]; end
        LA_THR:    thr_raw <= wdata;
        LA_E3LEN:  e3_raw  <= wdata;
        default:   ;
      endcase
    end
  end

  always_comb begin
    unique case (los_addr_e'(addr))
      LA_MASK:  rdata = W'({ana_dis, dig_dis});
      LA_THR:   rdata = thr_raw;
      LA_E3LEN: rdata = e3_raw;
      default:  rdata = W'(status);
    endcase
  end

endmodule

// File: rtl/los_zero_run.sv
module los_zero_run #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  input  logic         valid,
  input  logic         bit_in,
  input  logic [W-1:0] thr_eff,
  output logic         hit
);
  logic [W-1:0] zrun, thr_lat, lim;
  logic [W:0]   zrun_nxt;
  logic         run_start;

  assign run_start = (zrun == '0);
  assign lim       = run_start ? thr_eff : thr_lat;
  assign zrun_nxt  = {1'b0, zrun} + 1'b1;
  assign hit       = valid && !restart && !bit_in && (zrun_nxt == {1'b0, lim});

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      zrun    <= '0;
      thr_lat <= '0;
    end else if (valid) begin
      if (bit_in) begin
        zrun <= '0;
      end else begin
        if (run_start) thr_lat <= thr_eff;
        zrun <= hit ? '0 : zrun_nxt[W-1:0];
      end
    end
  end

  // R2
  run_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    hit |=> (zrun == '0));

  // R8
  run_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!valid && !restart) |=> $stable(zrun));

endmodule

// File: rtl/los_clear.sv
module los_clear #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  input  logic         valid,
  input  logic         bit_in,
  input  logic         e3,
  input  logic         los_on,
  input  logic         hit,
  input  logic [W-1:0] win_eff,
  input  logic [W-1:0] e3_eff,
  output logic         clr_evt
);
  import los_pkg::*;

  logic [W-1:0] cnt, ones, len_lat, len_use;
  logic [W:0]   cnt_nxt, ones_nxt;
  logic         starting, win_end, e3_done;

  assign starting = (cnt == '0);
  assign len_use  = starting ? (e3 ? e3_eff : win_eff) : len_lat;
  assign cnt_nxt  = {1'b0, cnt} + 1'b1;
  assign ones_nxt = {1'b0, ones} + {{W{1'b0}}, bit_in};
  assign win_end  = valid && !e3 && (cnt_nxt == {1'b0, len_use});
  assign e3_done  = valid && e3 && !starting && !hit && (cnt_nxt == {1'b0, len_use});
  assign clr_evt  = los_on && !restart &&
                    (e3 ? e3_done : (win_end && dense_enough(int'(ones_nxt), int'(len_use))));

  always_ff @(posedge clk) begin
    if (rst || restart || !los_on) begin
      cnt     <= '0;
      ones    <= '0;
      len_lat <= '0;
    end else if (valid) begin
      if (starting) len_lat <= e3 ? e3_eff : win_eff;
      if (e3) begin
        if (starting)             cnt <= bit_in ? W'(1) : '0;
        else if (hit || e3_done)  cnt <= '0;
        else                      cnt <= cnt_nxt[W-1:0];
      end else if (win_end) begin
        cnt  <= '0;
        ones <= '0;
      end else begin
        cnt  <= cnt_nxt[W-1:0];
        ones <= ones_nxt[W-1:0];
      end
    end
  end

  // R3
  ones_bound_chk: assert property (@(posedge clk) disable iff (rst)
    ones <= cnt);

  // R7
  e3_cancel_chk: assert property (@(posedge clk) disable iff (rst)
    (e3 && los_on && hit && !restart) |=> (cnt == '0));

endmodule

// File: rtl/los_monitor.sv
module los_monitor #(
  parameter int W          = 8,
  parameter int DEF_THR    = 175,
  parameter int DEF_E3_LEN = 32,
  parameter int DS3_MIN    = 100,
  parameter int DS3_MAX    = 250,
  parameter int E3_MIN     = 10,
  parameter int E3_MAX     = 255
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bit_valid,
  input  logic         bit_in,
  input  logic         e3_mode,
  input  logic         alos_in,
  input  logic         reg_wr,
  input  logic [1:0]   reg_addr,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  output logic         rlos
);
  import los_pkg::*;

  localparam int THR_LO = 0;

  logic         dig_dis, ana_dis, dlos, mode_q, restart, hit, clr_evt;
  logic [W-1:0] thr_raw, e3_raw, thr_eff, e3_eff;
  logic [2:0]   status;

  assign restart = (e3_mode != mode_q);
  assign thr_eff = W'(fit_range(int'(thr_raw) + THR_LO,
                                e3_mode ? E3_MIN : DS3_MIN,
                                e3_mode ? E3_MAX : DS3_MAX));
  assign e3_eff  = W'(fit_range(int'(e3_raw), E3_MIN, E3_MAX));
  assign rlos    = (dlos && !dig_dis) || (alos_in && !ana_dis);
  assign status  = {rlos, alos_in, dlos};

  always_ff @(posedge clk) begin
    if (rst) mode_q <= e3_mode;
    else     mode_q <= e3_mode;
  end

  always_ff @(posedge clk) begin
    if (rst)                  dlos <= 1'b0;
    else if (!dlos && hit)    dlos <= 1'b1;
    else if (dlos && clr_evt) dlos <= 1'b0;
  end

  los_regs #(.W(W), .DEF_THR(DEF_THR), .DEF_E3_LEN(DEF_E3_LEN)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .status(status), .rdata(reg_rdata), .dig_dis(dig_dis), .ana_dis(ana_dis),
    .thr_raw(thr_raw), .e3_raw(e3_raw)
  );

  los_zero_run #(.W(W)) u_run (
    .clk(clk), .rst(rst), .restart(restart), .valid(bit_valid), .bit_in(bit_in),
    .thr_eff(thr_eff), .hit(hit)
  );

  los_clear #(.W(W)) u_clr (
    .clk(clk), .rst(rst), .restart(restart), .valid(bit_valid), .bit_in(bit_in),
    .e3(e3_mode), .los_on(dlos), .hit(hit), .win_eff(thr_eff), .e3_eff(e3_eff),
    .clr_evt(clr_evt)
  );

  // R2
  dlos_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dlos) |-> $past(hit));

  // R3
  dlos_fall_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(dlos) && !$past(rst)) |-> $past(clr_evt));

  // R5
  both_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (dig_dis && ana_dis) |-> !rlos);

  // R4
  rlos_src_chk: assert property (@(posedge clk) disable iff (rst)
    rlos |-> (dlos || alos_in));

  // R9
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> $stable(dlos));

endmodule

// File: tb/los_monitor_test.sv
module los_monitor_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst, bit_valid, bit_in, e3_mode, alos_in, reg_wr;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       rlos;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  typedef struct { bit r; bit d; string tag; } exp_t;
  exp_t q[$];
  exp_t got;

  // reference state, kept from the requirements
  int  m_zr, m_zl, m_cnt, m_ones, m_len, m_thr, m_e3;
  bit  m_dl, m_mode, m_dd, m_ad, m_al;

  los_monitor uut (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_in(bit_in), .e3_mode(e3_mode),
    .alos_in(alos_in), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .rlos(rlos)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int lim_to(input int v, input int lo, input int hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  function automatic bit exp_rlos();
    return (m_dl && !m_dd) || (m_al && !m_ad);
  endfunction

  task automatic model_step(input bit b);
    int  thr_e, e3_e;
    bit  hit, ce;
    thr_e = m_mode ? lim_to(m_thr, 10, 255) : lim_to(m_thr, 100, 250);
    e3_e  = lim_to(m_e3, 10, 255);
    hit = 0; ce = 0;
    if (b) m_zr = 0;
    else begin
      if (m_zr == 0) m_zl = thr_e;
      if (m_zr + 1 == m_zl) begin hit = 1; m_zr = 0; end
      else m_zr = m_zr + 1;
    end
    if (m_dl) begin
      if (!m_mode) begin
        if (m_cnt == 0) m_len = thr_e;
        m_ones = m_ones + int'(b);
        if (m_cnt + 1 == m_len) begin
          ce = (3 * m_ones) > m_len; m_cnt = 0; m_ones = 0;
        end else m_cnt = m_cnt + 1;
      end else begin
        if (m_cnt == 0) begin
          if (b) begin m_cnt = 1; m_len = e3_e; end
        end else if (hit) m_cnt = 0;
        else if (m_cnt + 1 == m_len) begin ce = 1; m_cnt = 0; end
        else m_cnt = m_cnt + 1;
      end
    end else begin
      m_cnt = 0; m_ones = 0;
    end
    if (!m_dl && hit) m_dl = 1;
    else if (m_dl && ce) m_dl = 0;
  endtask

  task automatic push_exp(input string tag);
    exp_t e;
    e.r = exp_rlos(); e.d = m_dl; e.tag = tag;
    q.push_back(e);
  endtask

  // driver: one bit per cycle, expectation queued for the monitor
  task automatic send_bit(input bit v, input bit b, input string tag);
    @(negedge clk);
    bit_valid = v; bit_in = b; reg_wr = 0; reg_addr = 2'd3;
    if (v) model_step(b);
    push_exp(tag);
  endtask

  task automatic send_run(input int n, input bit b, input string tag);
    for (int i = 0; i < n; i++) send_bit(1, b, tag);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bit_valid = 0; reg_wr = 1; reg_addr = a; reg_wdata = d;
    if (a == 2'd0) begin m_dd = d[0]; m_ad = d[1]; end
    else if (a == 2'd1) m_thr = int'(d);
    else if (a == 2'd2) m_e3 = int'(d);
    @(negedge clk);
    reg_wr = 0; reg_addr = 2'd3;
  endtask

  task automatic check(input bit ok, input int act, input int expv, input string tag);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic rd(input logic [1:0] a, input int expv, input string tag);
    @(negedge clk);
    bit_valid = 0; reg_addr = a;
    #1;
    check(int'(reg_rdata) == expv, int'(reg_rdata), expv, tag);
  endtask

  task automatic expect_now(input bit er, input string tag);
    @(negedge clk);
    bit_valid = 0; reg_addr = 2'd3;
    #1;
    check(rlos === er, int'(rlos), int'(er), tag);
  endtask

  task automatic set_alos(input bit v, input string tag);
    @(negedge clk);
    bit_valid = 0; alos_in = v; m_al = v;
    push_exp(tag);
  endtask

  task automatic set_mode(input bit v, input string tag);
    @(negedge clk);
    bit_valid = 0; e3_mode = v; m_mode = v;
    m_zr = 0; m_cnt = 0; m_ones = 0;
    push_exp(tag);
  endtask

  // monitor: compares rlos and status bit 0 after each edge
  always @(posedge clk) begin
    #2;
    if (!rst && q.size() > 0) begin
      got = q.pop_front();
      checks++;
      if (rlos !== got.r || reg_rdata[0] !== got.d) begin
        errors++;
        $display("FAIL %s: rlos=%0b dlos=%0b expected rlos=%0b dlos=%0b",
                 got.tag, rlos, reg_rdata[0], got.r, got.d);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    rst = 1; bit_valid = 0; bit_in = 0; e3_mode = 0; alos_in = 0;
    reg_wr = 0; reg_addr = 2'd3; reg_wdata = '0;
    m_zr = 0; m_zl = 0; m_cnt = 0; m_ones = 0; m_len = 0;
    m_thr = 175; m_e3 = 32; m_dl = 0; m_mode = 0; m_dd = 0; m_ad = 0; m_al = 0;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state
    expect_now(0, "R1");
    rd(2'd0, 0, "R1");
    rd(2'd1, 175, "R1");
    rd(2'd2, 32, "R1");
    rd(2'd3, 0, "R1");

    // R2 declaration needs 175 unbroken zeros
    send_run(174, 0, "R2");
    send_bit(1, 1, "R2");
    send_run(174, 0, "R2");
    expect_now(0, "R2");
    send_bit(1, 0, "R2");
    expect_now(1, "R2");

    // R3 58 ones of 175 keep the flag, 59 clear it
    send_run(58, 1, "R3");
    send_run(117, 0, "R3");
    expect_now(1, "R3");
    send_run(59, 1, "R3");
    send_run(116, 0, "R3");
    expect_now(0, "R3");
    send_bit(1, 1, "R3");

    // R8 unqualified zeros do not count
    send_run(100, 0, "R8");
    for (int i = 0; i < 200; i++) send_bit(0, 0, "R8");
    send_run(74, 0, "R8");
    expect_now(0, "R8");
    send_bit(1, 0, "R8");
    expect_now(1, "R8");
    send_run(510, 1, "R3");

    // R4 / R5 combining and masks
    set_alos(1, "R4");
    expect_now(1, "R4");
    rd(2'd3, 6, "R4");
    wr(2'd0, 8'd1);
    expect_now(1, "R5");
    wr(2'd0, 8'd3);
    expect_now(0, "R5");
    send_run(175, 0, "R5");
    expect_now(0, "R5");
    rd(2'd3, 3, "R5");
    wr(2'd0, 8'd2);
    expect_now(1, "R5");
    set_alos(0, "R4");
    wr(2'd0, 8'd0);
    send_run(510, 1, "R3");

    // R11 status is read-only
    wr(2'd3, 8'hFF);
    rd(2'd3, 0, "R11");
    rd(2'd0, 0, "R11");

    // R10 threshold captured at run start
    send_run(10, 0, "R10");
    wr(2'd1, 8'd120);
    send_run(164, 0, "R10");
    expect_now(0, "R10");
    send_bit(1, 0, "R10");
    expect_now(1, "R10");
    send_run(510, 1, "R10");
    send_run(119, 0, "R10");
    expect_now(0, "R10");
    send_bit(1, 0, "R10");
    expect_now(1, "R10");
    send_run(510, 1, "R10");

    // R12 clamp to DS3 minimum, raw value read back
    wr(2'd1, 8'd20);
    rd(2'd1, 20, "R11");
    send_run(99, 0, "R12");
    expect_now(0, "R12");
    send_bit(1, 0, "R12");
    expect_now(1, "R12");
    send_run(510, 1, "R12");

    // R6 E3 declaration with threshold 20
    set_mode(1, "R9");
    wr(2'd2, 8'd12);
    rd(2'd2, 12, "R11");
    send_run(19, 0, "R6");
    expect_now(0, "R6");
    send_bit(1, 0, "R6");
    expect_now(1, "R6");

    // R7 clear on the 12th bit from the first one
    send_run(11, 1, "R7");
    expect_now(1, "R7");
    send_bit(1, 1, "R7");
    expect_now(0, "R7");

    // R7 a completed zero run cancels the count
    wr(2'd2, 8'd40);
    send_run(20, 0, "R7");
    expect_now(1, "R7");
    send_run(5, 1, "R7");
    send_run(20, 0, "R7");
    send_run(39, 1, "R7");
    expect_now(1, "R7");
    send_bit(1, 1, "R7");
    expect_now(0, "R7");

    // R9 mode change restarts the run
    wr(2'd1, 8'd60);
    send_run(50, 0, "R9");
    set_mode(0, "R9");
    send_run(99, 0, "R9");
    expect_now(0, "R9");
    send_bit(1, 0, "R9");
    expect_now(1, "R9");

    send_bit(0, 0, "R9");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule